// File: doc/BRIEF.md
# Clock Output Channel: Source Select and Post Divide

This block is one output channel of a clock generator that has several PLLs. It takes four free-running source clocks: three PLL outputs and a reference. It picks one of them and divides it by a programmable integer. The result goes to an output pad together with a separate pad output-enable. A configuration bank supplies the source-select and modulus fields. A power-down enable bit, a power-down pin, an output-enable pin and a control-set pin set the run state.

The channel can be built as a switchable channel (`ALT_SET = 1`). In that form it holds a second select/modulus set, and the level on the set pin chooses between the two sets with no reprogramming. Switching sets while a clock runs may glitch the output.

The source clocks are modelled as level signals sampled by a fast core clock. The divider counts the rising edges of the selected source that this clock samples. The PLLs and the oscillator lie outside the block.

Top module: `out_chan`

## Requirements
- R1: With every control field zero (source code 0, modulus code 0), `clk_out` equals `ref_clk` in the same cycle.
- R2: Source codes are 0 = reference, 1 = PLL A, 2 = PLL B, 3 = PLL C. A modulus code of 0 or 1 means divide by 1: `clk_out` follows the selected source combinationally.
- R3: A modulus code N >= 2 divides by N. Counting rising source edges since the last reload, edge j sets the output high when (j-1) mod N < N - floor(N/2) and low otherwise. The output is registered and changes at the core-clock edge that first samples the source high.
- R4: On a switchable channel, `set_pin` low uses `sel_set0`/`mod_set0` and `set_pin` high uses `sel_set1`/`mod_set1`, for both the source and the modulus.
- R5: When the effective modulus changes, the divider reloads at the next core-clock edge. The output drops low, and the next rising source edge starts a new high phase.
- R6: When `pd_pin` and `pd_en` are both 1, `clk_out` is 0 and the divider is held in reload. After release, the first rising source edge starts a high phase.
- R7: With `pd_en` = 0, `pd_pin` has no effect on `clk_out`.
- R8: `pad_oe` is 0 whenever `oe_pin` is 0, whatever the power state, and is 1 when `oe_pin` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_a_clk | input | 1 | PLL A output clock |
| pll_b_clk | input | 1 | PLL B output clock |
| pll_c_clk | input | 1 | PLL C output clock |
| ref_clk | input | 1 | Reference clock |
| sel_set0 | input | 2 | Source code, first set |
| mod_set0 | input | POST_MOD_W | Modulus code, first set |
| sel_set1 | input | 2 | Source code, second set |
| mod_set1 | input | POST_MOD_W | Modulus code, second set |
| set_pin | input | 1 | Picks control set (0 = first, 1 = second) |
| pd_en | input | 1 | Channel power-down enable bit |
| pd_pin | input | 1 | Power-down pin |
| oe_pin | input | 1 | Output enable pin |
| clk_out | output | 1 | Channel clock out |
| pad_oe | output | 1 | Pad output enable (0 = tristate) |

## Verification
Pass-through output and `pad_oe` are combinational: they are due in the same cycle as the inputs that set them. The divided output is due one core-clock edge after the source is first sampled high. A reload from a modulus change or power-down is visible one edge after the change is sampled. The bench drives every input on the falling edge. It updates its reference model from the values sampled at each rising edge and compares both outputs 2 ns after that edge, when both the combinational and the registered results have settled.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    parameter int unsigned POST_MOD_W = 8;
    parameter int unsigned NUM_SRC    = 4;
    localparam int unsigned SEL_W     = $clog2(NUM_SRC);

    typedef enum logic [SEL_W-1:0] {
        SRC_REF   = 2'd0,
        SRC_PLL_A = 2'd1,
        SRC_PLL_B = 2'd2,
        SRC_PLL_C = 2'd3
    } src_sel_e;

    typedef struct packed {
        src_sel_e                sel;
        logic [POST_MOD_W-1:0]   modc;
    } chan_ctrl_t;

    function automatic logic [POST_MOD_W-1:0] eff_mod(input logic [POST_MOD_W-1:0] code);
        return (code == '0) ? POST_MOD_W'(1) : code;
    endfunction

    function automatic logic [POST_MOD_W-1:0] high_len(input logic [POST_MOD_W-1:0] n);
        return n - (n >> 1);
    endfunction
endpackage

// File: rtl/chan_ctrl_pick.sv
module chan_ctrl_pick
    import clkdiv_pkg::*;
#(
    parameter bit ALT_SET = 1'b1
) (
    input  chan_ctrl_t set0,
    input  chan_ctrl_t set1,
    input  logic       set_pin,
    output chan_ctrl_t active
);
    generate
        if (ALT_SET) begin : g_switch
            assign active = set_pin ? set1 : set0;
        end else begin : g_fixed
            assign active = set0;
        end
    endgenerate
endmodule

// File: rtl/chan_src_mux.sv
module chan_src_mux
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] srcs,
    input  src_sel_e           sel,
    output logic               src_o,
    output logic               rise_o
);
    logic prev_q;

    assign src_o  = srcs[sel];
    assign rise_o = src_o & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= src_o;
    end
endmodule

// File: rtl/chan_post_div.sv
module chan_post_div
    import clkdiv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rise,
    input  logic                  hold,
    input  logic [POST_MOD_W-1:0] modc,
    output logic                  div_q,
    output logic                  bypass
);
    logic [POST_MOD_W-1:0] n_eff, n_hi, cnt_q, cnt_nxt, mod_q;
    logic                  reload;

    assign n_eff   = eff_mod(modc);
    assign n_hi    = high_len(n_eff);
    assign bypass  = (n_eff == POST_MOD_W'(1));
    assign reload  = hold | (n_eff != mod_q);
    assign cnt_nxt = (cnt_q >= n_eff - POST_MOD_W'(1)) ? '0 : cnt_q + POST_MOD_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            mod_q <= POST_MOD_W'(1);
            div_q <= 1'b0;
        end else begin
            mod_q <= n_eff;
            if (reload) begin
                cnt_q <= n_eff - POST_MOD_W'(1);
                div_q <= 1'b0;
            end else if (rise) begin
                cnt_q <= cnt_nxt;
                div_q <= (cnt_nxt < n_hi);
            end
        end
    end
endmodule

// File: rtl/out_chan.sv
module out_chan
    import clkdiv_pkg::*;
#(
    parameter bit ALT_SET = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pll_a_clk,
    input  logic                  pll_b_clk,
    input  logic                  pll_c_clk,
    input  logic                  ref_clk,
    input  logic [1:0]            sel_set0,
    input  logic [POST_MOD_W-1:0] mod_set0,
    input  logic [1:0]            sel_set1,
    input  logic [POST_MOD_W-1:0] mod_set1,
    input  logic                  set_pin,
    input  logic                  pd_en,
    input  logic                  pd_pin,
    input  logic                  oe_pin,
    output logic                  clk_out,
    output logic                  pad_oe
);
    chan_ctrl_t         set0, set1, act;
    logic [NUM_SRC-1:0] srcs;
    logic               src_sel, src_rise, div_q, bypass, hold;

    assign set0 = '{sel: src_sel_e'(sel_set0), modc: mod_set0};
    assign set1 = '{sel: src_sel_e'(sel_set1), modc: mod_set1};
    assign srcs = {pll_c_clk, pll_b_clk, pll_a_clk, ref_clk};
    assign hold = pd_pin & pd_en;

    chan_ctrl_pick #(.ALT_SET(ALT_SET)) u_pick (
        .set0(set0), .set1(set1), .set_pin(set_pin), .active(act)
    );

    chan_src_mux u_mux (
        .clk(clk), .rst(rst), .srcs(srcs), .sel(act.sel),
        .src_o(src_sel), .rise_o(src_rise)
    );

    chan_post_div u_div (
        .clk(clk), .rst(rst), .rise(src_rise), .hold(hold),
        .modc(act.modc), .div_q(div_q), .bypass(bypass)
    );

    assign clk_out = hold ? 1'b0 : (bypass ? src_sel : div_q);
    assign pad_oe  = oe_pin;
endmodule

// File: rtl/out_chan_chk.sv
module out_chan_chk
    import clkdiv_pkg::*;
#(
    parameter bit ALT_SET = 1'b1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  pll_a_clk,
    input logic                  ref_clk,
    input logic [1:0]            sel_set0,
    input logic [POST_MOD_W-1:0] mod_set0,
    input logic [1:0]            sel_set1,
    input logic [POST_MOD_W-1:0] mod_set1,
    input logic                  set_pin,
    input logic                  pd_en,
    input logic                  pd_pin,
    input logic                  oe_pin,
    input logic                  clk_out,
    input logic                  pad_oe,
    input logic                  src_rise,
    input logic [POST_MOD_W-1:0] act_mod,
    input logic                  div_q
);
    a_r1_zero_passes_ref: assert property (@(posedge clk) disable iff (rst)
        (!set_pin && sel_set0 == 2'd0 && mod_set0 == '0 && !(pd_pin && pd_en))
            |-> (clk_out == ref_clk));

    a_r3_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
        (!(pd_pin && pd_en) && !src_rise && $stable(act_mod)) |=> $stable(div_q));

    a_r6_pd_forces_low: assert property (@(posedge clk) disable iff (rst)
        (pd_pin && pd_en) |-> !clk_out);

    a_r8_oe_low_tristates: assert property (@(posedge clk) disable iff (rst)
        !oe_pin |-> !pad_oe);

    generate
        if (ALT_SET) begin : g_alt
            a_r4_second_set_used: assert property (@(posedge clk) disable iff (rst)
                (set_pin && sel_set1 == 2'd1 && mod_set1 == '0 && !(pd_pin && pd_en))
                    |-> (clk_out == pll_a_clk));
        end
    endgenerate
endmodule

bind out_chan out_chan_chk #(.ALT_SET(ALT_SET)) u_chk (
    .clk(clk), .rst(rst), .pll_a_clk(pll_a_clk), .ref_clk(ref_clk),
    .sel_set0(sel_set0), .mod_set0(mod_set0), .sel_set1(sel_set1), .mod_set1(mod_set1),
    .set_pin(set_pin), .pd_en(pd_en), .pd_pin(pd_pin), .oe_pin(oe_pin),
    .clk_out(clk_out), .pad_oe(pad_oe), .src_rise(src_rise),
    .act_mod(act.modc), .div_q(div_q)
);

// File: tb/tb_out_chan.sv
`timescale 1ns/1ps
module tb_out_chan;
    localparam int MW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pll_a_clk = 0, pll_b_clk = 0, pll_c_clk = 0, ref_clk = 0;
    logic [1:0]    sel_set0 = 0, sel_set1 = 0;
    logic [MW-1:0] mod_set0 = 0, mod_set1 = 0;
    logic set_pin = 0, pd_en = 0, pd_pin = 1, oe_pin = 1;
    logic clk_out, pad_oe;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";

    always #4 clk = ~clk;

    out_chan #(.ALT_SET(1'b1)) dut (
        .clk(clk), .rst(rst), .pll_a_clk(pll_a_clk), .pll_b_clk(pll_b_clk),
        .pll_c_clk(pll_c_clk), .ref_clk(ref_clk), .sel_set0(sel_set0),
        .mod_set0(mod_set0), .sel_set1(sel_set1), .mod_set1(mod_set1),
        .set_pin(set_pin), .pd_en(pd_en), .pd_pin(pd_pin), .oe_pin(oe_pin),
        .clk_out(clk_out), .pad_oe(pad_oe)
    );

    // free-running sources, half periods in core cycles: ref 3, A 2, B 5, C 4
    int ph_r = 0, ph_a = 0, ph_b = 0, ph_c = 0;
    always @(negedge clk) begin
        ph_r++; ph_a++; ph_b++; ph_c++;
        if (ph_r == 3) begin ph_r = 0; ref_clk   = ~ref_clk;   end
        if (ph_a == 2) begin ph_a = 0; pll_a_clk = ~pll_a_clk; end
        if (ph_b == 5) begin ph_b = 0; pll_b_clk = ~pll_b_clk; end
        if (ph_c == 4) begin ph_c = 0; pll_c_clk = ~pll_c_clk; end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    function automatic logic pick_src(input logic [1:0] s);
        case (s)
            2'd0: return ref_clk;
            2'd1: return pll_a_clk;
            2'd2: return pll_b_clk;
            default: return pll_c_clk;
        endcase
    endfunction

    logic m_prev = 0, m_q = 0;
    int   m_k = 0, m_seen = 1;

    always begin
        logic s, hold_m, expo;
        int   n, code;
        @(posedge clk);
        s      = pick_src(set_pin ? sel_set1 : sel_set0);
        code   = int'(set_pin ? mod_set1 : mod_set0);
        n      = (code == 0) ? 1 : code;
        hold_m = pd_pin && pd_en;
        if (rst) begin
            m_prev = 0; m_k = 0; m_q = 0; m_seen = 1;
        end else begin
            logic rise;
            rise   = s && !m_prev;
            m_prev = s;
            if (hold_m || n != m_seen) begin
                m_k = 0; m_q = 0;
            end else if (rise) begin
                m_k++;
                m_q = (((m_k - 1) % n) < (n - n / 2));
            end
            m_seen = n;
        end
        #2;
        expo = hold_m ? 1'b0 : ((n == 1) ? s : m_q);
        check(cur_req, clk_out, expo);
        check("R8", pad_oe, oe_pin);
    end

    task automatic run(input int cyc);
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cur_req = "R1"; run(30);
        cur_req = "R2";
        sel_set0 = 2'd1; run(20);
        sel_set0 = 2'd2; run(30);
        sel_set0 = 2'd3; run(30);
        mod_set0 = 8'd1; run(20);
        cur_req = "R3";
        sel_set0 = 2'd1;
        mod_set0 = 8'd2; run(60);
        mod_set0 = 8'd4; run(80);
        cur_req = "R5";
        mod_set0 = 8'd3; run(80);
        mod_set0 = 8'd5; run(100);
        cur_req = "R3";
        sel_set0 = 2'd0; mod_set0 = 8'd7; run(150);
        cur_req = "R4";
        sel_set1 = 2'd2; mod_set1 = 8'd6;
        set_pin = 1; run(150);
        set_pin = 0; run(80);
        sel_set1 = 2'd1; mod_set1 = 8'd0;
        set_pin = 1; run(40);
        set_pin = 0; mod_set0 = 8'd4; sel_set0 = 2'd1; run(40);
        cur_req = "R7";
        pd_en = 0; pd_pin = 1; run(60);
        cur_req = "R6";
        pd_en = 1; pd_pin = 1; run(40);
        pd_pin = 0; run(60);
        pd_pin = 1; mod_set0 = 8'd0; run(20);
        pd_pin = 0; run(20);
        cur_req = "R8";
        oe_pin = 0; run(30);
        pd_pin = 1; run(20);
        pd_pin = 0; mod_set0 = 8'd3; run(40);
        oe_pin = 1; run(20);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule